// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the event-driven part of an I2C controller's status byte. Three flags live here. The first marks that the controller currently owns the bus as master. The second records that the controller lost arbitration. The third records that the received address byte carried an extension code. The bus engine reports what happens on the bus through single-cycle strobes. The host influences the flags through a communication-exit command, through the controller enable and by reading the register.

The status byte places the three flags in its upper bits. The lower five bits are passed through unchanged from status sources that live outside this block, so the host reads one complete byte. All logic runs on one clock and has a synchronous active-low reset. A fall of the enable is found by comparing the enable with its value registered on the previous clock.

Top module: `i2c_status_reg`

## Requirements
- R1: After reset, status bits 7, 6 and 5 are all 0. With `low_status` at 0, the byte reads 00H.
- R2: Status bits 4..0 equal `low_status` in the same cycle, at all times.
- R3: A `start_gen` pulse sets bit 7 (master) on the next clock edge when no master-clear event occurs in the same cycle.
- R4: Bit 7 is cleared on the next edge after any of `stop_det`, `arb_lost`, `comm_exit`, or a 1-to-0 fall of `ctrl_en`. A clear in the same cycle as `start_gen` wins.
- R5: An `arb_lost` pulse sets bit 6 (arbitration lost) and clears bit 7 on the same edge.
- R6: A `host_rd` pulse clears bit 6 on the following edge. The byte seen during the read cycle still shows the old value. An `arb_lost` pulse in the same cycle as the read keeps bit 6 at 1.
- R7: A 1-to-0 fall of `ctrl_en` clears bit 6 on the next edge, even when `arb_lost` pulses in the same cycle.
- R8: A pulse on `addr_bit8_edge` sets bit 5 (extension code) when `rx_addr_hi` is 4'b0000 or 4'b1111. Any other value of `rx_addr_hi` leaves bit 5 at 0.
- R9: Bit 5 is cleared on the next edge after `start_det`, `stop_det`, `comm_exit`, or a 1-to-0 fall of `ctrl_en`. A clear in the same cycle as a set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_gen | input | 1 | Pulse: the controller generated a start condition |
| start_det | input | 1 | Pulse: a start condition was seen on the bus |
| stop_det | input | 1 | Pulse: a stop condition was seen on the bus |
| arb_lost | input | 1 | Pulse: arbitration was lost |
| addr_bit8_edge | input | 1 | Pulse: eighth rising SCL edge of the address byte |
| rx_addr_hi | input | 4 | Upper four bits of the received address byte |
| comm_exit | input | 1 | Host command to leave communication |
| ctrl_en | input | 1 | Controller enable level |
| host_rd | input | 1 | Host read strobe for the status byte |
| low_status | input | 5 | External status bits 4..0, passed through |
| status_q | output | 8 | Status byte |

## Verification
A flag held in the wrong state appears at its bit of `status_q` one clock after the strobe that should have changed it. The tests therefore check each bit in the cycle right after every set or clear event. A read-clear that acts too early shows in the read cycle itself, because the byte already reads 0 there. A wrong priority between a set and a clear in the same cycle shows one edge later as a flag with the wrong value. The edge detector for the enable matters only on the cycle of the fall, so a fault there shows as a flag that survives the disable.

// File: rtl/i2c_status_pkg.sv
// Package: bit positions and widths shared by the status register, its
// building blocks and its checker. Assumes an 8-bit status byte.
package i2c_status_pkg;
    localparam int STAT_W   = 8;
    localparam int MST_POS  = 7;
    localparam int ALD_POS  = 6;
    localparam int EXC_POS  = 5;
    localparam int LOW_W    = 5;
    localparam int NIB_W    = 4;

    // Clear and set events gathered for one flag.
    typedef struct packed {
        logic set;
        logic hard_clr;
        logic soft_clr;
    } flag_evt_t;
endpackage

// File: rtl/i2c_en_fall_det.sv
// Module: detects a 1-to-0 fall of the controller enable level.
// Assumes the enable is already synchronous to clk. The registered copy
// resets to 0, so no fall is reported in the first cycle after reset.
module i2c_en_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic fall
);
    logic en_prev;

    // Keep the enable value from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= en;
    end

    // A fall is a previous 1 with a current 0.
    always_comb fall = en_prev & ~en;
endmodule

// File: rtl/i2c_ext_code_dec.sv
// Module: decides whether the upper address bits form an extension code.
// Assumes the nibble is stable while the eighth-clock strobe is high.
module i2c_ext_code_dec #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] nib,
    input  logic             strobe,
    output logic             hit
);
    localparam logic [NIB_W-1:0] ALL_ZERO = '0;
    localparam logic [NIB_W-1:0] ALL_ONE  = '1;

    // Hit on all-zero or all-one nibble, qualified by the strobe.
    always_comb hit = strobe & ((nib == ALL_ZERO) | (nib == ALL_ONE));
endmodule

// File: rtl/i2c_flag_cell.sv
// Module: one status flag with prioritised set and clear events.
// The hard clear always wins. The set beats the soft clear when
// SET_OVER_SOFT is 1. Otherwise the soft clear beats the set.
module i2c_flag_cell
    import i2c_status_pkg::*;
#(
    parameter bit SET_OVER_SOFT = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  flag_evt_t evt,
    output logic      q
);
    logic q_nxt;

    // Choose the next flag value by event priority.
    generate
        if (SET_OVER_SOFT) begin : g_set_first
            always_comb begin
                if (evt.hard_clr)      q_nxt = 1'b0;
                else if (evt.set)      q_nxt = 1'b1;
                else if (evt.soft_clr) q_nxt = 1'b0;
                else                   q_nxt = q;
            end
        end else begin : g_soft_first
            always_comb begin
                if (evt.hard_clr | evt.soft_clr) q_nxt = 1'b0;
                else if (evt.set)                q_nxt = 1'b1;
                else                             q_nxt = q;
            end
        end
    endgenerate

    // Hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nxt;
    end
endmodule

// File: rtl/i2c_status_reg.sv
// Module: status byte of an I2C controller. Bit 7 is the master flag,
// bit 6 is arbitration lost and bit 5 is extension code received. Bits
// 4..0 pass through from outside. Assumes all strobes are one-cycle pulses
// synchronous to clk. The read-clear of bit 6 acts on the edge that ends
// the read cycle.
module i2c_status_reg
    import i2c_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_gen,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             arb_lost,
    input  logic             addr_bit8_edge,
    input  logic [NIB_W-1:0] rx_addr_hi,
    input  logic             comm_exit,
    input  logic             ctrl_en,
    input  logic             host_rd,
    input  logic [LOW_W-1:0] low_status,
    output logic [STAT_W-1:0] status_q
);
    logic      en_fall;
    logic      ext_hit;
    logic      mst_q, ald_q, exc_q;
    flag_evt_t mst_evt, ald_evt, exc_evt;

    i2c_en_fall_det u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl_en),
        .fall (en_fall)
    );

    i2c_ext_code_dec #(.NIB_W(NIB_W)) u_dec (
        .nib   (rx_addr_hi),
        .strobe(addr_bit8_edge),
        .hit   (ext_hit)
    );

    // Gather the set and clear events for each flag.
    always_comb begin
        mst_evt.set      = start_gen;
        mst_evt.hard_clr = stop_det | arb_lost | comm_exit | en_fall;
        mst_evt.soft_clr = 1'b0;

        ald_evt.set      = arb_lost;
        ald_evt.hard_clr = en_fall;
        ald_evt.soft_clr = host_rd;

        exc_evt.set      = ext_hit;
        exc_evt.hard_clr = start_det | stop_det | comm_exit | en_fall;
        exc_evt.soft_clr = 1'b0;
    end

    i2c_flag_cell #(.SET_OVER_SOFT(1'b1)) u_mst (
        .clk(clk), .rst_n(rst_n), .evt(mst_evt), .q(mst_q));
    i2c_flag_cell #(.SET_OVER_SOFT(1'b1)) u_ald (
        .clk(clk), .rst_n(rst_n), .evt(ald_evt), .q(ald_q));
    i2c_flag_cell #(.SET_OVER_SOFT(1'b1)) u_exc (
        .clk(clk), .rst_n(rst_n), .evt(exc_evt), .q(exc_q));

    // Assemble the status byte.
    always_comb begin
        status_q                = '0;
        status_q[MST_POS]       = mst_q;
        status_q[ALD_POS]       = ald_q;
        status_q[EXC_POS]       = exc_q;
        status_q[LOW_W-1:0]     = low_status;
    end
endmodule

// File: rtl/i2c_status_reg_chk.sv
// Checker: port-level properties of the status register, bound to it.
// It keeps its own registered enable copy, reset to 0, to find falls.
module i2c_status_reg_chk
    import i2c_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_gen,
    input logic              start_det,
    input logic              stop_det,
    input logic              arb_lost,
    input logic              addr_bit8_edge,
    input logic [NIB_W-1:0]  rx_addr_hi,
    input logic              comm_exit,
    input logic              ctrl_en,
    input logic              host_rd,
    input logic [STAT_W-1:0] status_q
);
    logic en_seen;
    logic dis;
    logic ext_nib;

    // Registered enable copy for the checker's own fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_seen <= 1'b0;
        else        en_seen <= ctrl_en;
    end

    always_comb dis     = en_seen & ~ctrl_en;
    always_comb ext_nib = (rx_addr_hi == '0) | (rx_addr_hi == '1);

    assert_mst_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_gen && !stop_det && !arb_lost && !comm_exit && !dis) |=> status_q[MST_POS]);

    assert_mst_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det || arb_lost || comm_exit || dis) |=> !status_q[MST_POS]);

    assert_ald_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !dis) |=> (status_q[ALD_POS] && !status_q[MST_POS]));

    assert_ald_rdclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !arb_lost) |=> !status_q[ALD_POS]);

    assert_ald_dis_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> !status_q[ALD_POS]);

    assert_exc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_bit8_edge && ext_nib && !start_det && !stop_det && !comm_exit && !dis)
        |=> status_q[EXC_POS]);

    assert_exc_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det || comm_exit || dis) |=> !status_q[EXC_POS]);
endmodule

bind i2c_status_reg i2c_status_reg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_gen     (start_gen),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .arb_lost      (arb_lost),
    .addr_bit8_edge(addr_bit8_edge),
    .rx_addr_hi    (rx_addr_hi),
    .comm_exit     (comm_exit),
    .ctrl_en       (ctrl_en),
    .host_rd       (host_rd),
    .status_q      (status_q)
);

// File: tb/i2c_status_reg_test.sv
// Directed bench: inputs change on the falling edge, and checks run on the
// falling edge after the rising edge that should update the flags.
module i2c_status_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_gen = 0, start_det = 0, stop_det = 0, arb_lost = 0;
    logic       addr_bit8_edge = 0, comm_exit = 0, ctrl_en = 0, host_rd = 0;
    logic [3:0] rx_addr_hi = 4'h0;
    logic [4:0] low_status = 5'h00;
    logic [7:0] status_q;
    int checks = 0, errors = 0;
    bit done = 0;

    i2c_status_reg uut (.*);

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic quiet();
        start_gen = 0; start_det = 0; stop_det = 0; arb_lost = 0;
        addr_bit8_edge = 0; comm_exit = 0; host_rd = 0;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset byte", status_q, 8'h00);
    endtask

    task automatic t_pass();
        low_status = 5'h15; #1;
        chk("R2 low bits", status_q, 8'h15);
        low_status = 5'h0A; #1;
        chk("R2 low bits", status_q, 8'h0A);
        low_status = 5'h00;
        step();
    endtask

    task automatic t_master();
        start_gen = 1; step(); quiet();
        chk("R3 master set", {7'b0, status_q[7]}, 8'h01);
        stop_det = 1; step(); quiet();
        chk("R4 stop clears master", {7'b0, status_q[7]}, 8'h00);
        start_gen = 1; step(); quiet();
        comm_exit = 1; step(); quiet();
        chk("R4 exit clears master", {7'b0, status_q[7]}, 8'h00);
        start_gen = 1; step(); quiet();
        ctrl_en = 0; step(); ctrl_en = 1; step();
        chk("R4 enable fall clears master", {7'b0, status_q[7]}, 8'h00);
        start_gen = 1; stop_det = 1; step(); quiet();
        chk("R4 clear wins over start", {7'b0, status_q[7]}, 8'h00);
    endtask

    task automatic t_arb();
        start_gen = 1; step(); quiet();
        arb_lost = 1; step(); quiet();
        chk("R5 arb set, master cleared", status_q[7:5], 3'b010);
        host_rd = 1; #1;
        chk("R6 read sees old value", {7'b0, status_q[6]}, 8'h01);
        step(); quiet();
        chk("R6 read clears arb", {7'b0, status_q[6]}, 8'h00);
        arb_lost = 1; host_rd = 1; step(); quiet();
        chk("R6 set beats read clear", {7'b0, status_q[6]}, 8'h01);
        step();
        chk("R6 arb holds without read", {7'b0, status_q[6]}, 8'h01);
        ctrl_en = 0; step(); ctrl_en = 1; step();
        chk("R7 enable fall clears arb", {7'b0, status_q[6]}, 8'h00);
        step();
        ctrl_en = 0; arb_lost = 1; step(); quiet(); ctrl_en = 1; step();
        chk("R7 enable fall beats arb set", {7'b0, status_q[6]}, 8'h00);
    endtask

    task automatic t_ext();
        rx_addr_hi = 4'h0; addr_bit8_edge = 1; step(); quiet();
        chk("R8 nibble 0000 sets ext", {7'b0, status_q[5]}, 8'h01);
        start_det = 1; step(); quiet();
        chk("R9 start clears ext", {7'b0, status_q[5]}, 8'h00);
        rx_addr_hi = 4'hF; addr_bit8_edge = 1; step(); quiet();
        chk("R8 nibble 1111 sets ext", {7'b0, status_q[5]}, 8'h01);
        stop_det = 1; step(); quiet();
        chk("R9 stop clears ext", {7'b0, status_q[5]}, 8'h00);
        rx_addr_hi = 4'h5; addr_bit8_edge = 1; step(); quiet();
        chk("R8 nibble 0101 ignored", {7'b0, status_q[5]}, 8'h00);
        rx_addr_hi = 4'h8; addr_bit8_edge = 1; step(); quiet();
        chk("R8 nibble 1000 ignored", {7'b0, status_q[5]}, 8'h00);
        rx_addr_hi = 4'hF; addr_bit8_edge = 1; step(); quiet();
        comm_exit = 1; step(); quiet();
        chk("R9 exit clears ext", {7'b0, status_q[5]}, 8'h00);
        rx_addr_hi = 4'h0; addr_bit8_edge = 1; step(); quiet();
        ctrl_en = 0; step(); ctrl_en = 1; step();
        chk("R9 enable fall clears ext", {7'b0, status_q[5]}, 8'h00);
        addr_bit8_edge = 1; start_det = 1; step(); quiet();
        chk("R9 clear wins over set", {7'b0, status_q[5]}, 8'h00);
    endtask

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1'b1; ctrl_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_master();
        t_arb();
        t_ext();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule